// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the microprogram counter of a microcoded processor and works out, every clock cycle, which control-store word runs next. The current word is read from a 512-entry by 36-bit control store inside the block and split into its fields. The next-address field and three branch-select bits then combine with two condition flags and an 8-bit byte from the memory byte register to form the following address. Those two flags, negative and zero, come from the previous cycle's ALU result.

The three branch selects act independently and may all be set in one word. The negative-select and zero-select bits together raise address bit 8 when either enabled flag is true. The byte-dispatch bit ORs the memory byte into the low eight address bits. All three contributions apply in the same cycle, with no precedence among them.

The control store is filled through a plain write port. That port accepts a word on every cycle its enable is high and applies no back-pressure. The counter advances on every clock edge. The decoded fields are outputs for the datapath, which lies outside this block.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `mpc` to 0. The control store and the flag latches are not cleared by reset.
- R2: With all three branch selects clear, the next `mpc` equals the current word's next-address field.
- R3: With the negative-select bit set, next `mpc[8]` is the field's bit 8 ORed with the latched negative flag.
- R4: With the zero-select bit set, next `mpc[8]` is the field's bit 8 ORed with the latched zero flag.
- R5: With both negative-select and zero-select set, bit 8 is raised when either flag is true. A field of 0x001 with the zero flag set leads to 0x101 whatever the negative flag is, and to 0x001 when both flags are clear.
- R6: With the byte-dispatch bit set, next `mpc[7:0]` is the field's low byte ORed with `mbr_byte`. This holds together with R3–R5 in the same word.
- R7: The 36-bit word is decoded MSB first into these fields: next-address field [35:27], byte-dispatch [26], negative-select [25], zero-select [24], ALU/shift control [23:16], C-bus enables [15:7], write [6], read [5], fetch [4], B-bus select [3:0]. The C-bus enables, from bit 15 down to bit 7, select H, OPC, TOS, CPP, LV, SP, PC, MDR, MAR.
- R8: The flags used for a transition are `alu_n`/`alu_z` as sampled at the previous rising edge. The values present during the current cycle do not affect that transition.
- R9: A word written through the load port at a rising edge becomes the decoded word from then on, whenever `mpc` addresses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Control-store write enable |
| ld_addr | input | 9 | Control-store write address |
| ld_word | input | 36 | Control-store write data |
| alu_n | input | 1 | ALU result negative, this cycle |
| alu_z | input | 1 | ALU result zero, this cycle |
| mbr_byte | input | 8 | Memory byte register value for dispatch |
| mpc | output | 9 | Registered microprogram counter |
| nxt_field | output | 9 | Decoded next-address field |
| sel_byte | output | 1 | Decoded byte-dispatch bit |
| sel_neg | output | 1 | Decoded negative-select bit |
| sel_zero | output | 1 | Decoded zero-select bit |
| alu_ctl | output | 8 | Decoded ALU/shift control |
| c_en | output | 9 | Decoded C-bus enables, H at MSB, MAR at LSB |
| mem_write | output | 1 | Decoded write strobe |
| mem_read | output | 1 | Decoded read strobe |
| mem_fetch | output | 1 | Decoded fetch strobe |
| b_sel | output | 4 | Decoded B-bus source select |

## Verification
The bench builds the block with its default 9-bit address. That gives the full 512-word store and puts the flag-driven branch on bit 8, so every branch target sits exactly 256 words above its fall-through. Running at that width exercises a set field bit 8 meeting a taken branch. It also covers a byte dispatch filling the whole low byte, and both flag selects active at once with only the zero flag true, which is the case a first-set-wins evaluation gets wrong. The flag inputs are inverted during each checked transition, so using the current-cycle flags in place of the latched ones would show up.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W = 9;
  localparam int ALU_W  = 8;
  localparam int CEN_W  = 9;
  localparam int BSEL_W = 4;
  localparam int WORD_W = ADDR_W + 3 + ALU_W + CEN_W + 3 + BSEL_W;

  // Field order is MSB first and is fixed by the word layout.
  typedef struct packed {
    logic [ADDR_W-1:0] nxt;
    logic              sel_byte;
    logic              sel_neg;
    logic              sel_zero;
    logic [ALU_W-1:0]  alu;
    logic [CEN_W-1:0]  cen;
    logic              wr;
    logic              rd;
    logic              fetch;
    logic [BSEL_W-1:0] bsel;
  } uword_t;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 9,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output uword_t            fields
);
  assign fields = uword_t'(word);
endmodule

// File: rtl/useq_next.sv
module useq_next #(
  parameter int AW = 9
) (
  input  logic [AW-1:0] field,
  input  logic          sel_byte,
  input  logic          sel_neg,
  input  logic          sel_zero,
  input  logic          n_flag,
  input  logic          z_flag,
  input  logic [AW-2:0] byte_in,
  output logic [AW-1:0] addr
);
  logic jam_hi;

  // Both flag selects are evaluated together; neither masks the other.
  assign jam_hi       = (sel_neg & n_flag) | (sel_zero & z_flag);
  assign addr[AW-1]   = field[AW-1] | jam_hi;

  for (genvar i = 0; i < AW - 1; i++) begin : g_low
    assign addr[i] = field[i] | (sel_byte & byte_in[i]);
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW = useq_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              alu_n,
  input  logic              alu_z,
  input  logic [AW-2:0]     mbr_byte,
  output logic [AW-1:0]     mpc,
  output logic [AW-1:0]     nxt_field,
  output logic              sel_byte,
  output logic              sel_neg,
  output logic              sel_zero,
  output logic [ALU_W-1:0]  alu_ctl,
  output logic [CEN_W-1:0]  c_en,
  output logic              mem_write,
  output logic              mem_read,
  output logic              mem_fetch,
  output logic [BSEL_W-1:0] b_sel
);
  logic [WORD_W-1:0] cur_word;
  uword_t            f;
  logic [AW-1:0]     next_addr;
  logic              n_q, z_q;

  useq_store #(.AW(AW), .DW(WORD_W)) u_store (
    .clk   (clk),
    .we    (ld_en),
    .waddr (ld_addr),
    .wdata (ld_word),
    .raddr (mpc),
    .rdata (cur_word)
  );

  useq_decode u_dec (
    .word   (cur_word),
    .fields (f)
  );

  useq_next #(.AW(AW)) u_next (
    .field    (f.nxt),
    .sel_byte (f.sel_byte),
    .sel_neg  (f.sel_neg),
    .sel_zero (f.sel_zero),
    .n_flag   (n_q),
    .z_flag   (z_q),
    .byte_in  (mbr_byte),
    .addr     (next_addr)
  );

  // Flag latches track the ALU every cycle, reset or not.
  always_ff @(posedge clk) begin
    n_q <= alu_n;
    z_q <= alu_z;
  end

  always_ff @(posedge clk) begin
    if (rst) mpc <= '0;
    else     mpc <= next_addr;
  end

  assign nxt_field = f.nxt;
  assign sel_byte  = f.sel_byte;
  assign sel_neg   = f.sel_neg;
  assign sel_zero  = f.sel_zero;
  assign alu_ctl   = f.alu;
  assign c_en      = f.cen;
  assign mem_write = f.wr;
  assign mem_read  = f.rd;
  assign mem_fetch = f.fetch;
  assign b_sel     = f.bsel;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          alu_n,
  input logic          alu_z,
  input logic [AW-2:0] mbr_byte,
  input logic [AW-1:0] mpc,
  input logic [AW-1:0] nxt_field,
  input logic          sel_byte,
  input logic          sel_neg,
  input logic          sel_zero
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> mpc == '0);

  // R2
  plain_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_byte && !sel_neg && !sel_zero) |=> mpc == $past(nxt_field));

  // R5 (also R3, R4, R8): bit 8 uses flags sampled one edge earlier
  high_bit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> mpc[AW-1] == ($past(nxt_field[AW-1])
      | ($past(sel_neg) & $past(alu_n, 2))
      | ($past(sel_zero) & $past(alu_z, 2))));

  // R6
  low_byte_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> mpc[AW-2:0] == ($past(nxt_field[AW-2:0])
      | ($past(sel_byte) ? $past(mbr_byte) : '0)));
endmodule

bind useq_sequencer useq_sequencer_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .alu_n     (alu_n),
  .alu_z     (alu_z),
  .mbr_byte  (mbr_byte),
  .mpc       (mpc),
  .nxt_field (nxt_field),
  .sel_byte  (sel_byte),
  .sel_neg   (sel_neg),
  .sel_zero  (sel_zero)
);

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [8:0]  ld_addr = '0;
  logic [35:0] ld_word = '0;
  logic        alu_n = 1'b0, alu_z = 1'b0;
  logic [7:0]  mbr_byte = '0;
  logic [8:0]  mpc, nxt_field;
  logic        sel_byte, sel_neg, sel_zero;
  logic [7:0]  alu_ctl;
  logic [8:0]  c_en;
  logic        mem_write, mem_read, mem_fetch;
  logic [3:0]  b_sel;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  useq_sequencer u_useq_sequencer (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
    .alu_n(alu_n), .alu_z(alu_z), .mbr_byte(mbr_byte), .mpc(mpc),
    .nxt_field(nxt_field), .sel_byte(sel_byte), .sel_neg(sel_neg),
    .sel_zero(sel_zero), .alu_ctl(alu_ctl), .c_en(c_en),
    .mem_write(mem_write), .mem_read(mem_read), .mem_fetch(mem_fetch),
    .b_sel(b_sel)
  );

  // {field[30:22], sel{byte,neg,zero}[21:19], n[18], z[17], mbr[16:9], expected[8:0]}
  localparam logic [30:0] VEC [13] = '{
    {9'h001, 3'b000, 1'b1, 1'b1, 8'hFF, 9'h001}, // R2
    {9'h001, 3'b010, 1'b1, 1'b0, 8'h00, 9'h101}, // R3
    {9'h001, 3'b010, 1'b0, 1'b1, 8'h00, 9'h001}, // R3
    {9'h001, 3'b001, 1'b0, 1'b1, 8'h00, 9'h101}, // R4
    {9'h001, 3'b001, 1'b1, 1'b0, 8'h00, 9'h001}, // R4
    {9'h001, 3'b011, 1'b0, 1'b1, 8'h00, 9'h101}, // R5
    {9'h001, 3'b011, 1'b1, 1'b0, 8'h00, 9'h101}, // R5
    {9'h001, 3'b011, 1'b0, 1'b0, 8'h00, 9'h001}, // R5
    {9'h040, 3'b100, 1'b0, 1'b0, 8'h83, 9'h0C3}, // R6
    {9'h100, 3'b100, 1'b0, 1'b0, 8'h7F, 9'h17F}, // R6
    {9'h010, 3'b111, 1'b0, 1'b1, 8'h05, 9'h115}, // R6
    {9'h1AA, 3'b011, 1'b0, 1'b0, 8'h00, 9'h1AA}, // R5
    {9'h0F0, 3'b110, 1'b1, 1'b0, 8'h0F, 9'h1FF}  // R6
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    // Clear the whole store under reset.
    @(negedge clk);
    ld_en = 1'b1;
    for (int a = 0; a < 512; a++) begin
      ld_addr = 9'(a);
      ld_word = '0;
      @(negedge clk);
    end
    ld_en = 1'b0;
    check("R1 reset", 36'(mpc), 36'h0);

    // Vector table: R8 flags are inverted during the checked transition.
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      rst = 1'b1;
      ld_en = 1'b1; ld_addr = 9'h000;
      ld_word = {VEC[i][30:22], VEC[i][21:19], 24'h000000};
      alu_n = VEC[i][18]; alu_z = VEC[i][17]; mbr_byte = VEC[i][16:9];
      @(negedge clk);
      ld_en = 1'b0; rst = 1'b0;
      alu_n = ~VEC[i][18]; alu_z = ~VEC[i][17];
      @(negedge clk);
      check($sformatf("R8 vec%0d", i), 36'(mpc), 36'(VEC[i][8:0]));
    end

    // R7 decode of a fully populated word at address 0.
    @(negedge clk);
    rst = 1'b1;
    ld_en = 1'b1; ld_addr = 9'h000; ld_word = {9'h123, 3'b101, 24'h5A1E3C};
    @(negedge clk);
    ld_en = 1'b0;
    check("R7 field", 36'(nxt_field), 36'h123);
    check("R7 selects", 36'({sel_byte, sel_neg, sel_zero}), 36'h5);
    check("R7 alu", 36'(alu_ctl), 36'h5A);
    check("R7 c_en", 36'(c_en), 36'h03C);
    check("R7 mem", 36'({mem_write, mem_read, mem_fetch}), 36'h3);
    check("R7 bsel", 36'(b_sel), 36'hC);

    // R9 chain: 0 -> 5 -> dispatch 0x3A -> 0.
    ld_en = 1'b1; ld_addr = 9'h000; ld_word = {9'h005, 3'b000, 24'h0};
    @(negedge clk);
    ld_addr = 9'h005; ld_word = {9'h010, 3'b100, 24'hC30081};
    @(negedge clk);
    ld_en = 1'b0; mbr_byte = 8'h2A; alu_n = 1'b1; alu_z = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    check("R9 step1", 36'(mpc), 36'h005);
    check("R9 word", 36'({alu_ctl, b_sel}), 36'hC31);
    @(negedge clk);
    check("R6 dispatch", 36'(mpc), 36'h03A);
    @(negedge clk);
    check("R2 zero word", 36'(mpc), 36'h000);
    @(negedge clk);
    check("R2 loop", 36'(mpc), 36'h005);
    rst = 1'b1;
    @(negedge clk);
    check("R1 midrun", 36'(mpc), 36'h000);
    @(negedge clk);
    check("R1 hold", 36'(mpc), 36'h000);

    summary();
    $finish;
  end
endmodule